// File: doc/BRIEF.md
# Run-Time Configurable CIC Decimator

This block turns a single-channel one-bit pulse-density stream into signed 24-bit PCM samples with a cascaded integrator-comb (sinc) filter. The filter order (1 to 5) and the decimation ratio (8 to 256 in powers of two, or off) are picked at run time from two 4-bit codes. The codes are captured only while the channel is idle, so a capture always runs with one fixed configuration.

Each accepted PDM bit is mapped to +1 or -1 and fed through a chain of running-sum stages. Once per decimation period, a chain of difference stages turns the result into one sample. That sample is then scaled so that full scale fills the 24-bit output. A small state machine controls capture: `ST_IDLE` (state cleared, codes sampled), `ST_RUN` (filtering and emitting samples) and `ST_MUTE` (enabled, but the ratio code disables decimation). The transitions are:
- `ST_IDLE -> ST_RUN` when `en` is high and the ratio code is valid.
- `ST_IDLE -> ST_MUTE` when `en` is high and the ratio code is not valid.
- `ST_RUN -> ST_IDLE` and `ST_MUTE -> ST_IDLE` when `en` is low.
- Every other case holds the current state.

Top module: `cic_decim`

## Requirements
- R1: After reset, `pcm_valid` is 0 and `pcm_sample` is 0. From the second rising edge after `en` falls, both stay 0 until a new capture produces a sample.
- R2: Bit 1 counts as +1 and bit 0 as -1. With order N and ratio R, sample m equals the sum over j of h[j]·x[mR-1-j], where h is the coefficient set of (1+z^-1+...+z^-(R-1))^N and inputs from before the capture count as 0.
- R3: `order_code` (mode-word bits 23:20) selects order 1..5 directly. Any other value (0 or 6..15) selects order 3.
- R4: `ratio_code` (mode-word bits 27:24) value c in 1..6 gives R = 2^(c+2). Exactly one `pcm_valid` pulse is produced per R accepted bits, one cycle after the edge that accepts the R-th bit.
- R5: A ratio code of 0 or 7..15 produces no samples at all while `en` is high.
- R6: With S = N·log2(R), the filter sum y is clamped to at most 2^S-1. It is then shifted right by S-23 when S ≥ 23, or left by 23-S otherwise, and the low 24 bits are output.
- R7: The codes are sampled only while idle. Changing them during a capture has no effect on that capture's samples.
- R8: Deasserting `en` clears all filter state. A new capture behaves as if it started from reset.
- R9: A bit is accepted only on a rising edge where `pdm_valid` and `en` are both high and the block is in `ST_RUN`. `pdm_bit` is ignored otherwise.
- R10: No internal overflow occurs at order 5 and ratio 256. After settling, a steady all-ones input gives 0x7FFFFF and a steady all-zeros input gives 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low clears the filter |
| order_code | input | 4 | Filter order code |
| ratio_code | input | 4 | Decimation ratio code |
| pdm_bit | input | 1 | PDM data bit |
| pdm_valid | input | 1 | Qualifies `pdm_bit` |
| pcm_sample | output | 24 | Signed PCM sample |
| pcm_valid | output | 1 | One-cycle strobe per new sample |

## Verification
The bench compares every sample against a direct FIR evaluation built from the polynomial coefficients. This exposes a filter that taps the wrong stage for the selected order, or one whose decimation phase is off by one bit. The clamp-and-shift rule is exercised at both extremes. At order 5 and ratio 256, a steady all-ones input must give 0x7FFFFF and a steady all-zeros input 0x800000; an undersized accumulator would wrap and give the wrong sign, and a missing clamp would wrap all-ones to negative. Further cases cover invalid order and ratio codes, codes scrambled mid-capture, gaps with toggling data, and a restart after a partial period. A design that sampled codes while running, or kept stale state across a restart, would produce mismatched samples; one that counted non-valid cycles would produce too many samples.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int ORDER_MAX_DEF   = 5;
    localparam int LOG2R_MAX_DEF   = 8;
    localparam int PCM_W_DEF       = 24;
    localparam int ORDER_FALLBACK  = 3;
    localparam int RATIO_CODE_BIAS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_MUTE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
    parameter int STAGES = cic_pkg::ORDER_MAX_DEF,
    parameter int W      = 42
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] x_in,
    output logic [W-1:0] acc_nx [STAGES]
);
    logic [W-1:0] acc_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign acc_nx[i] = acc_q[i] + x_in;
        end else begin : g_rest
            assign acc_nx[i] = acc_q[i] + acc_nx[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     acc_q[i] <= '0;
            else if (clr)   acc_q[i] <= '0;
            else if (step)  acc_q[i] <= acc_nx[i];
        end
    end
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
    parameter int STAGES = cic_pkg::ORDER_MAX_DEF,
    parameter int W      = 42
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout [STAGES]
);
    logic [W-1:0] dly_q [STAGES];
    logic [W-1:0] stin  [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stin[i] = din;
        end else begin : g_rest
            assign stin[i] = dout[i-1];
        end

        assign dout[i] = stin[i] - dly_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     dly_q[i] <= '0;
            else if (clr)   dly_q[i] <= '0;
            else if (step)  dly_q[i] <= stin[i];
        end
    end
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
    parameter int W     = 42,
    parameter int SW    = 6,
    parameter int PCM_W = cic_pkg::PCM_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk,
    input  logic signed [W-1:0] y_in,
    input  logic [SW-1:0]       s_bits,
    output logic [PCM_W-1:0]    pcm
);
    localparam logic [SW-1:0] MSB_POS = SW'(PCM_W - 1);

    logic signed [W-1:0] lim_mag, lim_pos, y_sat, y_adj;

    always_comb begin
        lim_mag = W'(1) <<< s_bits;
        lim_pos = lim_mag - W'(1);
        y_sat   = (y_in > lim_pos) ? lim_pos : y_in;
        if (s_bits >= MSB_POS) y_adj = y_sat >>> (s_bits - MSB_POS);
        else                   y_adj = y_sat <<< (MSB_POS - s_bits);
        pcm = y_adj[PCM_W-1:0];
    end

    // R10: filter sum never leaves the representable +/-2^S band
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        chk |-> (y_in <= lim_mag && y_in >= -lim_mag))
        else $error("filter sum outside range");
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
    parameter int ORDER_MAX = cic_pkg::ORDER_MAX_DEF,
    parameter int LOG2R_MAX = cic_pkg::LOG2R_MAX_DEF,
    parameter int PCM_W     = cic_pkg::PCM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [3:0]       order_code,
    input  logic [3:0]       ratio_code,
    input  logic             pdm_bit,
    input  logic             pdm_valid,
    output logic [PCM_W-1:0] pcm_sample,
    output logic             pcm_valid
);
    import cic_pkg::*;

    localparam int ACC_W    = 2 + ORDER_MAX * LOG2R_MAX;
    localparam int OW       = $clog2(ORDER_MAX + 1);
    localparam int LW       = $clog2(LOG2R_MAX + 1);
    localparam int SW       = $clog2(ORDER_MAX * LOG2R_MAX + 1);
    localparam int CODE_MAX = LOG2R_MAX - RATIO_CODE_BIAS;

    cap_state_e state_q, state_d;

    logic [OW-1:0]        order_q, order_d;
    logic [LW-1:0]        log2r_q, log2r_d;
    logic [SW-1:0]        s_q;
    logic [LOG2R_MAX-1:0] phase_q, rmask;
    logic                 accept, last_ph, tick, clr;
    logic [ACC_W-1:0]     x_in, tap, comb_res;
    logic [ACC_W-1:0]     integ_nx [ORDER_MAX];
    logic [ACC_W-1:0]     comb_out [ORDER_MAX];
    logic [PCM_W-1:0]     scaled, pcm_q;
    logic                 valid_q;

    // code decode (used only while idle)
    always_comb begin
        if (order_code != 4'd0 && order_code <= 4'(ORDER_MAX)) order_d = OW'(order_code);
        else                                                   order_d = OW'(ORDER_FALLBACK);
        if (ratio_code != 4'd0 && ratio_code <= 4'(CODE_MAX))
            log2r_d = LW'(ratio_code) + LW'(RATIO_CODE_BIAS);
        else
            log2r_d = '0;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = (log2r_d != '0) ? ST_RUN : ST_MUTE;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            ST_MUTE: if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // configuration capture, only in idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order_q <= OW'(ORDER_FALLBACK);
            log2r_q <= '0;
            s_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            order_q <= order_d;
            log2r_q <= log2r_d;
            s_q     <= SW'(int'(order_d) * int'(log2r_d));
        end
    end

    assign clr     = (state_q == ST_IDLE);
    assign accept  = (state_q == ST_RUN) && en && pdm_valid;
    assign rmask   = LOG2R_MAX'((1 << log2r_q) - 1);
    assign last_ph = (phase_q == rmask);
    assign tick    = accept && last_ph;
    assign x_in    = {{(ACC_W-1){~pdm_bit}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase_q <= '0;
        else if (clr)    phase_q <= '0;
        else if (accept) phase_q <= last_ph ? '0 : phase_q + 1'b1;
    end

    cic_integ #(.STAGES(ORDER_MAX), .W(ACC_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(accept),
        .x_in(x_in), .acc_nx(integ_nx)
    );

    always_comb begin
        tap = integ_nx[0];
        for (int i = 0; i < ORDER_MAX; i++)
            if (order_q == OW'(i + 1)) tap = integ_nx[i];
    end

    cic_comb #(.STAGES(ORDER_MAX), .W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(tick),
        .din(tap), .dout(comb_out)
    );

    always_comb begin
        comb_res = comb_out[0];
        for (int i = 0; i < ORDER_MAX; i++)
            if (order_q == OW'(i + 1)) comb_res = comb_out[i];
    end

    cic_scale #(.W(ACC_W), .SW(SW), .PCM_W(PCM_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .chk(tick),
        .y_in(comb_res), .s_bits(s_q), .pcm(scaled)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcm_q   <= '0;
            valid_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            pcm_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick;
            if (tick) pcm_q <= scaled;
        end
    end

    assign pcm_sample = pcm_q;
    assign pcm_valid  = valid_q;

    // R4: a ratio of at least 8 never yields back-to-back strobes
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid) else $error("back-to-back strobe");

    // R4: strobes only follow a running cycle
    a_r4_run_only: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(state_q) == ST_RUN) else $error("strobe outside run");

    // R5: muted channel stays silent
    a_r5_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MUTE |-> !pcm_valid) else $error("sample while muted");

    // R7: configuration frozen once capture has started
    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> $stable(order_q) && $stable(log2r_q))
        else $error("config changed during capture");

    // R8: dropping enable returns to idle without a strobe
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == ST_IDLE && !pcm_valid) else $error("enable low not honoured");

    // R3: latched order always legal
    a_r3_order_legal: assert property (@(posedge clk) disable iff (!rst_n)
        order_q >= OW'(1) && order_q <= OW'(ORDER_MAX)) else $error("order out of range");
endmodule

// File: tb/sim_cic_decim.sv
`timescale 1ns/1ps
module sim_cic_decim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  order_code = 4'd0;
    logic [3:0]  ratio_code = 4'd0;
    logic        pdm_bit = 1'b0;
    logic        pdm_valid = 1'b0;
    logic [23:0] pcm_sample;
    logic        pcm_valid;

    cic_decim u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .order_code(order_code),
        .ratio_code(ratio_code), .pdm_bit(pdm_bit), .pdm_valid(pdm_valid),
        .pcm_sample(pcm_sample), .pcm_valid(pcm_valid)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    longint      h [0:1279];
    longint      g [0:1279];
    int          hlen;
    int          xh [0:4095];
    int          nx;
    int          cur_order, cur_lg;
    logic [23:0] expq [$];
    logic [23:0] last_pcm;
    int          n_out = 0;
    int          n_out_start;
    string       cur_req = "R2";

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] scale_ref(input longint y, input int s);
        longint top, v;
        top = (longint'(1) << s) - 1;
        v = (y > top) ? top : y;
        if (s >= 23) v = v >>> (s - 23);
        else         v = v <<< (23 - s);
        return v[23:0];
    endfunction

    task automatic build_h(input int n, input int r);
        hlen = 1;
        h[0] = 1;
        for (int st = 0; st < n; st++) begin
            int nl;
            nl = hlen + r - 1;
            for (int i = 0; i < nl; i++) begin
                g[i] = 0;
                for (int t = 0; t < r; t++)
                    if (i - t >= 0 && i - t < hlen) g[i] += h[i - t];
            end
            for (int i = 0; i < nl; i++) h[i] = g[i];
            hlen = nl;
        end
    endtask

    function automatic longint fir_at(input int cnt);
        longint acc;
        acc = 0;
        for (int j = 0; j < hlen; j++)
            if (cnt - 1 - j >= 0) acc += h[j] * longint'(xh[cnt - 1 - j]);
        return acc;
    endfunction

    // sample monitor
    always @(negedge clk) begin
        if (rst_n && pcm_valid) begin
            n_out++;
            last_pcm = pcm_sample;
            if (expq.size() == 0)
                check(1'b0, "R5 R9 unexpected sample", longint'(pcm_sample), 0);
            else begin
                logic [23:0] e;
                e = expq.pop_front();
                check(pcm_sample == e, {cur_req, " R6 sample value"}, longint'(pcm_sample), longint'(e));
            end
        end
    end

    task automatic start_capture(input int ocode, input int rcode, input string req);
        @(negedge clk);
        en = 1'b0;
        order_code = 4'(ocode);
        ratio_code = 4'(rcode);
        repeat (2) @(negedge clk);
        en = 1'b1;
        cur_req = req;
        cur_order = (ocode >= 1 && ocode <= 5) ? ocode : 3;   // R3 fallback
        cur_lg = (rcode >= 1 && rcode <= 6) ? rcode + 2 : 0;  // R4 / R5
        if (cur_lg != 0) build_h(cur_order, 1 << cur_lg);
        nx = 0;
        n_out_start = n_out;
        @(negedge clk);
    endtask

    function automatic bit pat_bit(input int pat, input int i);
        case (pat)
            1: return 1'b1;
            2: return 1'b0;
            3: return (i % 5) < 3;
            default: return 1'($urandom_range(0, 1));
        endcase
    endfunction

    task automatic feed(input int nbits, input int pat, input bit scramble);
        for (int i = 0; i < nbits; i++) begin
            int gap;
            bit b;
            gap = $urandom_range(0, 2);
            for (int k = 0; k < gap; k++) begin
                @(negedge clk);
                pdm_valid = 1'b0;
                pdm_bit = 1'($urandom_range(0, 1));   // R9: ignored
                if (scramble) begin
                    order_code = 4'($urandom_range(0, 15));
                    ratio_code = 4'($urandom_range(0, 15));
                end
            end
            @(negedge clk);
            b = pat_bit(pat, i);
            pdm_valid = 1'b1;
            pdm_bit = b;
            if (scramble) begin
                order_code = 4'($urandom_range(0, 15));
                ratio_code = 4'($urandom_range(0, 15));
            end
            xh[nx] = b ? 1 : -1;
            nx++;
            if (cur_lg != 0 && (nx % (1 << cur_lg)) == 0)
                expq.push_back(scale_ref(fir_at(nx), cur_order * cur_lg));
        end
        @(negedge clk);
        pdm_valid = 1'b0;
    endtask

    task automatic stop_capture();
        int nexp;
        @(negedge clk);
        pdm_valid = 1'b0;
        en = 1'b0;
        repeat (3) @(negedge clk);
        nexp = (cur_lg != 0) ? nx / (1 << cur_lg) : 0;
        check(n_out - n_out_start == nexp, "R4 R5 sample count", n_out - n_out_start, nexp);
        check(expq.size() == 0, "R4 pending samples", expq.size(), 0);
        check(pcm_valid == 1'b0 && pcm_sample == 24'd0, "R1 R8 idle outputs",
              longint'({pcm_valid, pcm_sample}), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'h1234_5678);
        repeat (3) @(negedge clk);
        check(pcm_valid == 1'b0 && pcm_sample == 24'd0, "R1 reset state",
              longint'({pcm_valid, pcm_sample}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pcm_valid == 1'b0 && pcm_sample == 24'd0, "R1 idle after reset",
              longint'({pcm_valid, pcm_sample}), 0);

        // R2 order 1, ratio 8, random
        start_capture(1, 1, "R2");   feed(128, 0, 1'b0); stop_capture();
        // R2 order 3, ratio 32, periodic density
        start_capture(3, 3, "R2");   feed(320, 3, 1'b0); stop_capture();
        // R2 order 5, ratio 8
        start_capture(5, 1, "R2");   feed(160, 0, 1'b0); stop_capture();
        // R4 order 2, ratio 256
        start_capture(2, 6, "R4");   feed(1024, 0, 1'b0); stop_capture();
        // R4 order 4, ratio 16 and R6 small shift
        start_capture(4, 2, "R6");   feed(256, 3, 1'b0); stop_capture();
        // R3 invalid order codes fall back to 3
        start_capture(0, 2, "R3");   feed(192, 0, 1'b0); stop_capture();
        start_capture(12, 4, "R3");  feed(384, 0, 1'b0); stop_capture();
        // R5 disabled ratio codes
        start_capture(3, 0, "R5");   feed(96, 0, 1'b0); stop_capture();
        start_capture(2, 9, "R5");   feed(96, 1, 1'b0); stop_capture();
        // R7 codes scrambled during capture
        start_capture(4, 3, "R7");   feed(320, 0, 1'b1); stop_capture();
        // R8 partial period then restart with same codes
        start_capture(3, 2, "R8");   feed(40, 0, 1'b0); stop_capture();
        start_capture(3, 2, "R8");   feed(96, 0, 1'b0); stop_capture();
        // R10 extremes at order 5, ratio 256
        start_capture(5, 6, "R10");  feed(2048, 1, 1'b0);
        check(last_pcm == 24'h7FFFFF, "R10 positive full scale", longint'(last_pcm), 24'h7FFFFF);
        stop_capture();
        start_capture(5, 6, "R10");  feed(2048, 2, 1'b0);
        check(last_pcm == 24'h800000, "R10 negative full scale", longint'(last_pcm), 24'h800000);
        stop_capture();
        // constrained random mix
        for (int k = 0; k < 4; k++) begin
            int oc, rc;
            oc = $urandom_range(1, 5);
            rc = $urandom_range(1, 4);
            start_capture(oc, rc, "R2");
            feed(8 << (rc + 2), 0, 1'b0);
            stop_capture();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule